// File: doc/BRIEF.md
# Multiplexed Timer Slot Ring

This block keeps sixteen small timers in one slot store and services them in a fixed rotation. Each slot holds a 4-bit state and an 8-bit count. A four-phase sequencer visits one slot per rotation of four clock cycles. It reads that slot, forms a new count with a single 8-bit adder, and writes the slot back. The same adder also serves host commands. One slot is therefore touched every four cycles, and a full pass over all slots takes 64 cycles.

A host issues a 16-bit command word that either loads a slot or adds to a slot at an explicit address. Only one command is held at a time, and it is written during the rotation's third phase. A slot whose state has its top bit set counts down by one on each visit. When its count reaches zero the slot stops counting and a wake flag is raised, which stays up until the host acknowledges it. A readback word, driven inverted, reports the state, count and slot number of the slot read in the current rotation.

Top module: `tsr_ring`

## Requirements
- R1: Synchronous reset empties every slot (state 0, count 0), sets the pointer to slot 0 and the phase to 0, clears the pending command and the wake flag, and makes `rb_n_o` read 16'hFFFF.
- R2: `phase_o` follows the cycle 0, 3, 2, 1 and then repeats, advancing once per clock.
- R3: The command word carries the state in bits [15:12], the data operand in bits [11:4] and the slot address in bits [3:0].
- R4: A load command (`cmd_add_i`=0) writes the operand unchanged into the addressed slot's count and writes the command state, whatever the slot held before.
- R5: An add command (`cmd_add_i`=1) writes (stored count + operand) mod 256 into the addressed slot and writes the command state.
- R6: In the clock edge where `phase_o` is 2, `rb_n_o` is loaded with ~{state, count, slot}, taken from the slot read at the phase-0 edge of that rotation. The slot number rises by one per rotation (four cycles) and wraps from 15 to 0.
- R7: On each visit, a slot whose state bit 3 is set and whose count is non-zero has its count reduced by one. With a zero count, or with bit 3 clear, the visit leaves the slot unchanged.
- R8: When a visit brings a counting slot to zero, state bit 3 of that slot is cleared and `wake_o` rises after the phase-1 edge. The flag then stays high while `wake_ack_i` is low.
- R9: `wake_ack_i` held high for one clock clears `wake_o`. A new expiry in the same cycle wins over the acknowledge.
- R10: A new command replaces any pending one. Only the most recent command is written, and the pending flag is cleared by its write.
- R11: A pending command is written at the phase-3 edge. If it targets the slot the ring read in that rotation, the ring's phase-1 write-back is suppressed, so the host value survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_valid_i | input | 1 | Accept a host command this cycle |
| cmd_add_i | input | 1 | 1 = add operand to slot, 0 = load operand |
| cmd_word_i | input | 16 | Command: state [15:12], operand [11:4], slot [3:0] |
| wake_ack_i | input | 1 | Clears the wake flag |
| phase_o | output | 2 | Current sequencer phase |
| rb_n_o | output | 16 | Inverted readback: state, count, slot number |
| wake_o | output | 1 | Wake request from an expired counting slot |

## Verification
The assertions assume that reset is held for at least one clock before any check matters. They also assume that `wake_ack_i` and `cmd_valid_i` are plain level inputs sampled at the rising edge, with no protocol of their own. The bench drives every input on the falling edge, so no command or acknowledge lands on an ambiguous edge. Before issuing a command, the bench waits until the phase is not 3, so that the write always happens at the next phase-3 edge. The one exception is the override test, which places two commands back to back on purpose.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    // Rotation order: 0 -> 3 -> 2 -> 1 -> 0
    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_0:    return PH_3;
            PH_3:    return PH_2;
            PH_2:    return PH_1;
            default: return PH_0;
        endcase
    endfunction

endpackage

// File: rtl/tsr_seq.sv
module tsr_seq
    import tsr_pkg::*;
#(
    parameter  int NUM_SLOTS = 16,
    localparam int ADDR_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(NUM_SLOTS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.phase = next_phase(seq_q.phase);
        if (seq_q.phase == PH_1) begin
            if (seq_q.ptr == LAST_SLOT) begin
                seq_d.ptr = '0;
            end else begin
                seq_d.ptr = seq_q.ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign ptr_o   = seq_q.ptr;

endmodule

// File: rtl/tsr_store.sv
module tsr_store #(
    parameter  int NUM_SLOTS = 16,
    parameter  int ST_W      = 4,
    parameter  int CNT_W     = 8,
    localparam int ADDR_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [ST_W-1:0]   wstate_i,
    input  logic [CNT_W-1:0]  wcount_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [ST_W-1:0]   rstate_o,
    output logic [CNT_W-1:0]  rcount_o
);

    typedef struct packed {
        logic [ST_W-1:0]  st;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t slot_d [NUM_SLOTS];
    slot_t slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (we_i && (waddr_i == ADDR_W'(g))) begin
                slot_d[g].st  = wstate_i;
                slot_d[g].cnt = wcount_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    always_comb begin
        rstate_o = slot_q[raddr_i].st;
        rcount_o = slot_q[raddr_i].cnt;
    end

endmodule

// File: rtl/tsr_adder.sv
module tsr_adder #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] stored_i,
    input  logic [CNT_W-1:0] oper_i,
    input  logic             zero_stored_i,
    input  logic             force_ones_i,
    output logic [CNT_W-1:0] sum_o
);

    logic [CNT_W-1:0] lhs;
    logic [CNT_W-1:0] rhs;

    always_comb begin
        lhs   = zero_stored_i ? '0 : stored_i;
        rhs   = force_ones_i ? '1 : oper_i;
        sum_o = lhs + rhs;
    end

endmodule

// File: rtl/tsr_ring.sv
module tsr_ring
    import tsr_pkg::*;
#(
    parameter  int NUM_SLOTS = 16,
    parameter  int ST_W      = 4,
    parameter  int CNT_W     = 8,
    localparam int ADDR_W    = $clog2(NUM_SLOTS),
    localparam int WORD_W    = ST_W + CNT_W + ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_add_i,
    input  logic [WORD_W-1:0] cmd_word_i,
    input  logic              wake_ack_i,
    output logic [1:0]        phase_o,
    output logic [WORD_W-1:0] rb_n_o,
    output logic              wake_o
);

    localparam int DAT_LSB = ADDR_W;
    localparam int ST_LSB  = ADDR_W + CNT_W;
    localparam logic [ST_W-1:0] RUN_CLR = {1'b0, {(ST_W-1){1'b1}}};

    typedef struct packed {
        logic              pend;
        logic              add;
        logic [ST_W-1:0]   c_st;
        logic [CNT_W-1:0]  c_dat;
        logic [ADDR_W-1:0] c_addr;
        logic              hit;
        logic [ST_W-1:0]   rd_st;
        logic [CNT_W-1:0]  rd_cnt;
        logic [WORD_W-1:0] rb;
        logic              wake;
    } ring_t;

    ring_t st_d, st_q;

    phase_e            phase;
    logic [ADDR_W-1:0] ring_ptr;
    logic              cmd_pend;

    logic              host_we;
    logic              ring_we;
    logic              counting;
    logic              expire;
    logic [ADDR_W-1:0] mem_raddr;
    logic [ST_W-1:0]   mem_rstate;
    logic [CNT_W-1:0]  mem_rcount;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ST_W-1:0]   mem_wstate;
    logic [CNT_W-1:0]  add_stored;
    logic [CNT_W-1:0]  add_oper;
    logic              add_zero;
    logic              add_ones;
    logic [CNT_W-1:0]  add_sum;

    tsr_seq #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_o (phase),
        .ptr_o   (ring_ptr)
    );

    tsr_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .ST_W      (ST_W),
        .CNT_W     (CNT_W)
    ) u_store (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .we_i     (mem_we),
        .waddr_i  (mem_waddr),
        .wstate_i (mem_wstate),
        .wcount_i (add_sum),
        .raddr_i  (mem_raddr),
        .rstate_o (mem_rstate),
        .rcount_o (mem_rcount)
    );

    tsr_adder #(
        .CNT_W (CNT_W)
    ) u_adder (
        .stored_i      (add_stored),
        .oper_i        (add_oper),
        .zero_stored_i (add_zero),
        .force_ones_i  (add_ones),
        .sum_o         (add_sum)
    );

    // Datapath steering: the host owns the adder in phase 3, the ring in phase 1
    always_comb begin
        host_we   = (phase == PH_3) && st_q.pend;
        ring_we   = (phase == PH_1) && !st_q.hit;
        counting  = st_q.rd_st[ST_W-1] && (st_q.rd_cnt != '0);
        mem_raddr = (phase == PH_3) ? st_q.c_addr : ring_ptr;

        if (host_we) begin
            add_stored = mem_rcount;
            add_oper   = st_q.c_dat;
            add_zero   = !st_q.add;
            add_ones   = 1'b0;
        end else begin
            add_stored = st_q.rd_cnt;
            add_oper   = '0;
            add_zero   = 1'b0;
            add_ones   = counting;
        end

        expire     = ring_we && counting && (add_sum == '0);
        mem_we     = host_we || ring_we;
        mem_waddr  = host_we ? st_q.c_addr : ring_ptr;
        if (host_we) begin
            mem_wstate = st_q.c_st;
        end else if (expire) begin
            mem_wstate = st_q.rd_st & RUN_CLR;
        end else begin
            mem_wstate = st_q.rd_st;
        end
    end

    // Next-state of the control and capture registers
    always_comb begin
        st_d = st_q;

        case (phase)
            PH_0: begin
                st_d.rd_st  = mem_rstate;
                st_d.rd_cnt = mem_rcount;
            end
            PH_3: begin
                if (st_q.pend) begin
                    st_d.pend = 1'b0;
                    st_d.hit  = (st_q.c_addr == ring_ptr);
                end
            end
            PH_2: begin
                st_d.rb = {st_q.rd_st, st_q.rd_cnt, ring_ptr};
            end
            default: begin
                st_d.hit = 1'b0;
            end
        endcase

        if (wake_ack_i) begin
            st_d.wake = 1'b0;
        end
        if (expire) begin
            st_d.wake = 1'b1;
        end

        if (cmd_valid_i) begin
            st_d.pend   = 1'b1;
            st_d.add    = cmd_add_i;
            st_d.c_st   = cmd_word_i[ST_LSB +: ST_W];
            st_d.c_dat  = cmd_word_i[DAT_LSB +: CNT_W];
            st_d.c_addr = cmd_word_i[0 +: ADDR_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_pend = st_q.pend;
    assign phase_o  = phase;
    assign rb_n_o   = ~st_q.rb;
    assign wake_o   = st_q.wake;

endmodule

// File: rtl/tsr_ring_chk.sv
module tsr_ring_chk #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [1:0]        phase_i,
    input logic [ADDR_W-1:0] ptr_i,
    input logic [WORD_W-1:0] rb_n_i,
    input logic              wake_i,
    input logic              wake_ack_i,
    input logic              pend_i,
    input logic              cmd_valid_i
);

    assert_order_0_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_i == 2'd0 |=> phase_i == 2'd3);
    assert_order_3_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_i == 2'd3 |=> phase_i == 2'd2);
    assert_order_2_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_i == 2'd2 |=> phase_i == 2'd1);
    assert_order_1_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_i == 2'd1 |=> phase_i == 2'd0);

    assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(ptr_i) |-> ($past(phase_i) == 2'd1));

    assert_rb_update_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(rb_n_i) |-> ($past(phase_i) == 2'd2));

    assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_i && !wake_ack_i |=> wake_i);

    assert_wake_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wake_i) |-> ($past(phase_i) == 2'd1));

    assert_pend_consumed_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        pend_i && (phase_i == 2'd3) && !cmd_valid_i |=> !pend_i);

endmodule

bind tsr_ring tsr_ring_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_tsr_ring_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_i     (phase_o),
    .ptr_i       (ring_ptr),
    .rb_n_i      (rb_n_o),
    .wake_i      (wake_o),
    .wake_ack_i  (wake_ack_i),
    .pend_i      (cmd_pend),
    .cmd_valid_i (cmd_valid_i)
);

// File: tb/test_tsr_ring.sv
module test_tsr_ring;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_add;
    logic [15:0] cmd_word;
    logic        wake_ack;
    logic [1:0]  phase;
    logic [15:0] rb_n;
    logic        wake;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tsr_ring i_tsr_ring (
        .clk_i       (clk),
        .rst_i       (rst),
        .cmd_valid_i (cmd_valid),
        .cmd_add_i   (cmd_add),
        .cmd_word_i  (cmd_word),
        .wake_ack_i  (wake_ack),
        .phase_o     (phase),
        .rb_n_o      (rb_n),
        .wake_o      (wake)
    );

    function automatic logic [15:0] exp_rb(input logic [3:0] s, input logic [7:0] c, input logic [3:0] n);
        return ~{s, c, n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_phase(input logic [1:0] p);
        int guard = 0;
        step();
        while (phase != p && guard < 16) begin
            step();
            guard++;
        end
    endtask

    task automatic send_cmd(input bit add, input logic [3:0] s, input logic [7:0] d, input logic [3:0] a);
        while (phase == 2'd3) step();
        cmd_valid = 1'b1;
        cmd_add   = add;
        cmd_word  = {s, d, a};
        step();
        cmd_valid = 1'b0;
        cmd_add   = 1'b0;
        cmd_word  = '0;
    endtask

    // wait until the phase-3 write is done and the rotation has closed
    task automatic settle();
        wait_phase(2'd2);
        wait_phase(2'd0);
    endtask

    task automatic read_slot(input int n, output logic [15:0] w, output int cyc);
        logic [3:0] nn;
        nn  = n[3:0];
        cyc = 0;
        do begin
            step();
            cyc++;
        end while (!(phase == 2'd1 && rb_n[3:0] == ~nn) && cyc < 200);
        w = rb_n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int          cyc;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [3:0]  sl;

        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_add   = 1'b0;
        cmd_word  = '0;
        wake_ack  = 1'b0;
        repeat (3) step();
        rst = 1'b0;

        // R1: reset state
        check(rb_n == 16'hFFFF && phase == 2'd0 && wake == 1'b0, "R1 reset outputs",
              {rb_n[15:3], phase, wake}, {13'h1FFF, 2'd0, 1'b0});

        // R1, R6: every slot empty, slot number advances once per rotation
        for (int n = 0; n < 17; n++) begin
            read_slot(n % 16, w, cyc);
            check(w == exp_rb(4'h0, 8'h00, 4'(n % 16)), "R1 empty slot", w, exp_rb(4'h0, 8'h00, 4'(n % 16)));
            if (n > 0) check(cyc == 4, "R6 one slot per rotation", 16'(cyc), 16'd4);
        end

        // R3, R4, R5: load then add, swept over operands and slots
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                a  = 8'(i * 37 + 5);
                b  = 8'(j * 29 + 3);
                sl = 4'((i + j) % 16);
                send_cmd(1'b0, 4'(i & 7), a, sl);
                settle();
                if (j == 0) begin
                    read_slot(int'(sl), w, cyc);
                    check(w == exp_rb(4'(i & 7), a, sl), "R4 load", w, exp_rb(4'(i & 7), a, sl));
                end
                send_cmd(1'b1, 4'(j & 7), b, sl);
                settle();
                read_slot(int'(sl), w, cyc);
                check(w == exp_rb(4'(j & 7), a + b, sl), "R5 add", w, exp_rb(4'(j & 7), a + b, sl));
            end
        end

        // R10: second command replaces the first before it is written
        send_cmd(1'b0, 4'h1, 8'h01, 4'd7);
        settle();
        send_cmd(1'b0, 4'h1, 8'h02, 4'd8);
        settle();
        wait_phase(2'd2);
        send_cmd(1'b0, 4'h3, 8'h11, 4'd7);
        send_cmd(1'b0, 4'h4, 8'h22, 4'd8);
        settle();
        read_slot(7, w, cyc);
        check(w == exp_rb(4'h1, 8'h01, 4'd7), "R10 replaced command not written", w, exp_rb(4'h1, 8'h01, 4'd7));
        read_slot(8, w, cyc);
        check(w == exp_rb(4'h4, 8'h22, 4'd8), "R10 newest command written", w, exp_rb(4'h4, 8'h22, 4'd8));

        // R11: add to the slot the ring is reading this rotation
        send_cmd(1'b0, 4'h2, 8'h20, 4'd5);
        settle();
        read_slot(4, w, cyc);
        step();
        send_cmd(1'b1, 4'h6, 8'h05, 4'd5);
        settle();
        read_slot(5, w, cyc);
        check(w == exp_rb(4'h6, 8'h25, 4'd5), "R11 host write kept", w, exp_rb(4'h6, 8'h25, 4'd5));

        // R7, R8, R9: a counting slot runs down to zero
        send_cmd(1'b0, 4'hA, 8'h03, 4'd9);
        settle();
        for (int k = 3; k >= 1; k--) begin
            read_slot(9, w, cyc);
            check(w == exp_rb(4'hA, 8'(k), 4'd9), "R7 count down", w, exp_rb(4'hA, 8'(k), 4'd9));
            check(wake == 1'b0, "R8 no wake before zero", 16'(wake), 16'd0);
        end
        step();
        check(wake == 1'b1, "R8 wake after expiry", 16'(wake), 16'd1);
        read_slot(9, w, cyc);
        check(w == exp_rb(4'h2, 8'h00, 4'd9), "R8 run bit cleared", w, exp_rb(4'h2, 8'h00, 4'd9));
        read_slot(9, w, cyc);
        check(w == exp_rb(4'h2, 8'h00, 4'd9), "R7 stopped slot unchanged", w, exp_rb(4'h2, 8'h00, 4'd9));
        check(wake == 1'b1, "R8 wake held without ack", 16'(wake), 16'd1);
        wake_ack = 1'b1;
        step();
        wake_ack = 1'b0;
        check(wake == 1'b0, "R9 ack clears wake", 16'(wake), 16'd0);

        // R7: counting slot with zero count stays put, no wake
        send_cmd(1'b0, 4'h8, 8'h00, 4'd10);
        settle();
        for (int k = 0; k < 2; k++) begin
            read_slot(10, w, cyc);
            check(w == exp_rb(4'h8, 8'h00, 4'd10), "R7 zero count holds", w, exp_rb(4'h8, 8'h00, 4'd10));
        end
        step();
        check(wake == 1'b0, "R7 zero count raises no wake", 16'(wake), 16'd0);

        // R2: phase order observed at the port
        for (int k = 0; k < 8; k++) begin
            logic [1:0] prev;
            prev = phase;
            step();
            check(phase == 2'(prev - 2'd1), "R2 phase order", 16'(phase), 16'(2'(prev - 2'd1)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule